// File: doc/BRIEF.md
# Last-Arrive Edge Classifier

This block watches instructions as they retire from an out-of-order core and, for each one, names the single dependence that arrived last at each of the instruction's three timing nodes: fetch, execute and commit. The core supplies a few event flags with every retirement. These flags say whether the branch before this instruction was mispredicted, whether fetch was held because the reorder buffer was full, whether all operands were ready when the instruction was fetched, and whether the commit pointer had to wait for this instruction to execute. The core also supplies the arrival stamps and producer identifiers of up to `NSRC` source operands.

Only last-arriving edges can lie on the critical path, so the block emits one compact record per retired instruction and never builds a weighted graph. Each node gets a 3-bit edge code and the identifier of the instruction whose node drives that edge. A token-propagation analyzer downstream can walk these records in retirement order. The block keeps the identifier of the most recently retired instruction, which is the producer of every fetch-to-fetch, commit-to-fetch, execute-to-fetch and commit-to-commit edge.

Top module: `last_arrive_classifier`

## Requirements
- R1: While reset is high, and on the first clock after it falls, `out_valid` is 0. Reset also clears the record of the most recently retired instruction.
- R2: For each cycle with `ret_valid`=1, the next cycle shows `out_valid`=1 with `out_id` equal to that `ret_id`. A cycle with `ret_valid`=0 gives `out_valid`=0 in the next cycle. At most one retirement is accepted per cycle.
- R3: Edge codes are 0=F→F, 1=C→F, 2=E→F, 3=F→E, 4=E→E, 5=E→C, 6=C→C, 7=none. When `brmisp_prev`=1 and a predecessor exists, `f_kind` is 2 and `f_prod` is the predecessor's identifier.
- R4: When `brmisp_prev`=0 and a predecessor exists, `f_kind` is 1 if `rob_full_at_fetch`=1 and 0 otherwise. In both cases `f_prod` is the predecessor's identifier.
- R5: When `ops_ready_at_fetch`=1, or when no source is valid, `e_kind` is 3 and `e_prod` is the instruction's own `ret_id`.
- R6: Otherwise `e_kind` is 4 and `e_prod` is the producer of the valid source with the largest arrival stamp. Stamps are unsigned and taken from bits [g*TS_W +: TS_W] of `src_time`. Producers come from bits [g*ID_W +: ID_W] of `src_prod`. Sources are masked by `src_valid[g]`.
- R7: When several valid sources share the largest stamp, the one with the lowest index g is chosen.
- R8: When `commit_waited`=1, `c_kind` is 5 and `c_prod` is the own `ret_id`. Otherwise `c_kind` is 6 and `c_prod` is the predecessor's identifier.
- R9: For the first retirement after reset there is no predecessor. In that case `f_kind` is 7 with `f_prod`=0, and, unless `commit_waited`=1, `c_kind` is 7 with `c_prod`=0.
- R10: Idle cycles leave the predecessor unchanged. After a gap, the predecessor is still the last instruction that actually retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_id | input | ID_W | Identifier of the retiring instruction |
| brmisp_prev | input | 1 | The preceding branch was mispredicted |
| rob_full_at_fetch | input | 1 | Fetch of this instruction waited on a full reorder buffer |
| ops_ready_at_fetch | input | 1 | All source data was available at fetch |
| src_valid | input | NSRC | Per-source valid mask |
| src_time | input | NSRC*TS_W | Per-source arrival stamps, packed |
| src_prod | input | NSRC*ID_W | Per-source producer identifiers, packed |
| commit_waited | input | 1 | Commit pointer waited for this instruction's execution |
| out_valid | output | 1 | Record strobe |
| out_id | output | ID_W | Identifier of the classified instruction |
| f_kind | output | 3 | Fetch-node edge code |
| f_prod | output | ID_W | Fetch-node producer |
| e_kind | output | 3 | Execute-node edge code |
| e_prod | output | ID_W | Execute-node producer |
| c_kind | output | 3 | Commit-node edge code |
| c_prod | output | ID_W | Commit-node producer |

## Verification
Every record is due exactly one clock after its retirement cycle, because the only register between the inputs and the outputs is the output stage. The bench drives each retirement on a falling edge. On the next falling edge it compares every field with a value worked out from the flags and stamps it applied, and only then applies the following stimulus. Idle cycles placed inside the sweep check the absent strobe one cycle later, and they check that the fetch and commit producers still point at the last real retirement.

// File: rtl/lae_pkg.sv
package lae_pkg;

    typedef enum logic [2:0] {
        EDGE_FF   = 3'd0,
        EDGE_CF   = 3'd1,
        EDGE_EF   = 3'd2,
        EDGE_FE   = 3'd3,
        EDGE_EE   = 3'd4,
        EDGE_EC   = 3'd5,
        EDGE_CC   = 3'd6,
        EDGE_NONE = 3'd7
    } edge_kind_e;

    // Fetch node: redirect after mispredict wins over a reorder-buffer hold.
    function automatic edge_kind_e fetch_kind(input logic misp,
                                              input logic rob_hold,
                                              input logic have_prev);
        if (!have_prev)    return EDGE_NONE;
        else if (misp)     return EDGE_EF;
        else if (rob_hold) return EDGE_CF;
        else               return EDGE_FF;
    endfunction

    // Commit node: own execution when commit waited, else previous commit.
    function automatic edge_kind_e commit_kind(input logic waited,
                                               input logic have_prev);
        if (waited)          return EDGE_EC;
        else if (!have_prev) return EDGE_NONE;
        else                 return EDGE_CC;
    endfunction

endpackage

// File: rtl/lae_fetch_rule.sv
module lae_fetch_rule
    import lae_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            misp,
    input  logic            rob_hold,
    input  logic            have_prev,
    input  logic [ID_W-1:0] prev_id,
    output edge_kind_e      kind,
    output logic [ID_W-1:0] prod
);
    always_comb begin
        kind = fetch_kind(misp, rob_hold, have_prev);
        prod = (kind == EDGE_NONE) ? '0 : prev_id;
    end
endmodule

// File: rtl/lae_exec_pick.sv
module lae_exec_pick
    import lae_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int TS_W = 6,
    parameter int ID_W = 8
) (
    input  logic                 ready_at_fetch,
    input  logic [NSRC-1:0]      src_valid,
    input  logic [NSRC*TS_W-1:0] src_time,
    input  logic [NSRC*ID_W-1:0] src_prod,
    input  logic [ID_W-1:0]      own_id,
    output edge_kind_e           kind,
    output logic [ID_W-1:0]      prod
);
    // Scan chain across sources: stage g holds the latest arrival seen so far.
    // Strict comparison keeps the earlier (lower-index) source on a tie.
    logic [NSRC:0] seen;
    logic [TS_W-1:0] best_t [NSRC+1];
    logic [ID_W-1:0] best_p [NSRC+1];

    assign seen[0]   = 1'b0;
    assign best_t[0] = '0;
    assign best_p[0] = '0;

    for (genvar g = 0; g < NSRC; g++) begin : g_scan
        logic [TS_W-1:0] t_g;
        logic [ID_W-1:0] p_g;
        logic            take;
        assign t_g  = src_time[g*TS_W +: TS_W];
        assign p_g  = src_prod[g*ID_W +: ID_W];
        assign take = src_valid[g] && (!seen[g] || (t_g > best_t[g]));
        assign seen[g+1]   = seen[g] | src_valid[g];
        assign best_t[g+1] = take ? t_g : best_t[g];
        assign best_p[g+1] = take ? p_g : best_p[g];
    end

    always_comb begin
        if (ready_at_fetch || !seen[NSRC]) begin
            kind = EDGE_FE;
            prod = own_id;
        end else begin
            kind = EDGE_EE;
            prod = best_p[NSRC];
        end
    end
endmodule

// File: rtl/lae_commit_rule.sv
module lae_commit_rule
    import lae_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            waited,
    input  logic            have_prev,
    input  logic [ID_W-1:0] prev_id,
    input  logic [ID_W-1:0] own_id,
    output edge_kind_e      kind,
    output logic [ID_W-1:0] prod
);
    always_comb begin
        kind = commit_kind(waited, have_prev);
        unique case (kind)
            EDGE_EC: prod = own_id;
            EDGE_CC: prod = prev_id;
            default: prod = '0;
        endcase
    end
endmodule

// File: rtl/last_arrive_classifier.sv
module last_arrive_classifier
    import lae_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int TS_W = 6,
    parameter int ID_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ret_valid,
    input  logic [ID_W-1:0]      ret_id,
    input  logic                 brmisp_prev,
    input  logic                 rob_full_at_fetch,
    input  logic                 ops_ready_at_fetch,
    input  logic [NSRC-1:0]      src_valid,
    input  logic [NSRC*TS_W-1:0] src_time,
    input  logic [NSRC*ID_W-1:0] src_prod,
    input  logic                 commit_waited,
    output logic                 out_valid,
    output logic [ID_W-1:0]      out_id,
    output logic [2:0]           f_kind,
    output logic [ID_W-1:0]      f_prod,
    output logic [2:0]           e_kind,
    output logic [ID_W-1:0]      e_prod,
    output logic [2:0]           c_kind,
    output logic [ID_W-1:0]      c_prod
);
    // Most recently retired instruction: producer of F->F, C->F, E->F, C->C.
    logic            have_prev;
    logic [ID_W-1:0] prev_id;

    edge_kind_e      f_k_d, e_k_d, c_k_d;
    logic [ID_W-1:0] f_p_d, e_p_d, c_p_d;
    edge_kind_e      f_k_q, e_k_q, c_k_q;
    logic [ID_W-1:0] f_p_q, e_p_q, c_p_q;

    lae_fetch_rule #(.ID_W(ID_W)) u_fetch (
        .misp      (brmisp_prev),
        .rob_hold  (rob_full_at_fetch),
        .have_prev (have_prev),
        .prev_id   (prev_id),
        .kind      (f_k_d),
        .prod      (f_p_d)
    );

    lae_exec_pick #(.NSRC(NSRC), .TS_W(TS_W), .ID_W(ID_W)) u_exec (
        .ready_at_fetch (ops_ready_at_fetch),
        .src_valid      (src_valid),
        .src_time       (src_time),
        .src_prod       (src_prod),
        .own_id         (ret_id),
        .kind           (e_k_d),
        .prod           (e_p_d)
    );

    lae_commit_rule #(.ID_W(ID_W)) u_commit (
        .waited    (commit_waited),
        .have_prev (have_prev),
        .prev_id   (prev_id),
        .own_id    (ret_id),
        .kind      (c_k_d),
        .prod      (c_p_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_id   <= '0;
        end else if (ret_valid) begin
            have_prev <= 1'b1;
            prev_id   <= ret_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_id    <= '0;
            f_k_q     <= EDGE_NONE;
            e_k_q     <= EDGE_NONE;
            c_k_q     <= EDGE_NONE;
            f_p_q     <= '0;
            e_p_q     <= '0;
            c_p_q     <= '0;
        end else begin
            out_valid <= ret_valid;
            if (ret_valid) begin
                out_id <= ret_id;
                f_k_q  <= f_k_d;
                e_k_q  <= e_k_d;
                c_k_q  <= c_k_d;
                f_p_q  <= f_p_d;
                e_p_q  <= e_p_d;
                c_p_q  <= c_p_d;
            end
        end
    end

    assign f_kind = f_k_q;
    assign e_kind = e_k_q;
    assign c_kind = c_k_q;
    assign f_prod = f_p_q;
    assign e_prod = e_p_q;
    assign c_prod = c_p_q;
endmodule

// File: rtl/lae_checker.sv
module lae_checker #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            ret_valid,
    input logic [ID_W-1:0] ret_id,
    input logic            brmisp_prev,
    input logic            rob_full_at_fetch,
    input logic            ops_ready_at_fetch,
    input logic            commit_waited,
    input logic            out_valid,
    input logic [ID_W-1:0] out_id,
    input logic [2:0]      f_kind,
    input logic [ID_W-1:0] f_prod,
    input logic [2:0]      e_kind,
    input logic [ID_W-1:0] e_prod,
    input logic [2:0]      c_kind,
    input logic [ID_W-1:0] c_prod
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    assert_record_follows_R2: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> (out_valid && out_id == $past(ret_id)));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !ret_valid |=> !out_valid);

    assert_misp_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && brmisp_prev) |=> (f_kind == 3'd2 || f_kind == 3'd7));

    assert_rob_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !brmisp_prev && rob_full_at_fetch) |=> (f_kind == 3'd1 || f_kind == 3'd7));

    assert_ready_exec_R5: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ops_ready_at_fetch) |=> (e_kind == 3'd3 && e_prod == $past(ret_id)));

    assert_wait_commit_R8: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && commit_waited) |=> (c_kind == 3'd5 && c_prod == $past(ret_id)));

    assert_none_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && f_kind == 3'd7) |-> (f_prod == '0 && (c_kind == 3'd5 || c_prod == '0)));
endmodule

bind last_arrive_classifier lae_checker #(.ID_W(ID_W)) u_lae_checker (
    .clk                (clk),
    .rst                (rst),
    .ret_valid          (ret_valid),
    .ret_id             (ret_id),
    .brmisp_prev        (brmisp_prev),
    .rob_full_at_fetch  (rob_full_at_fetch),
    .ops_ready_at_fetch (ops_ready_at_fetch),
    .commit_waited      (commit_waited),
    .out_valid          (out_valid),
    .out_id             (out_id),
    .f_kind             (f_kind),
    .f_prod             (f_prod),
    .e_kind             (e_kind),
    .e_prod             (e_prod),
    .c_kind             (c_kind),
    .c_prod             (c_prod)
);

// File: tb/last_arrive_classifier_bench.sv
`timescale 1ns/1ps
module last_arrive_classifier_bench;
    localparam int NSRC = 3;
    localparam int TS_W = 2;
    localparam int ID_W = 8;
    localparam int SWEEP = 1 << (NSRC*TS_W + NSRC + 4);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 ret_valid = 1'b0;
    logic [ID_W-1:0]      ret_id = '0;
    logic                 brmisp_prev = 1'b0;
    logic                 rob_full_at_fetch = 1'b0;
    logic                 ops_ready_at_fetch = 1'b0;
    logic [NSRC-1:0]      src_valid = '0;
    logic [NSRC*TS_W-1:0] src_time = '0;
    logic [NSRC*ID_W-1:0] src_prod = '0;
    logic                 commit_waited = 1'b0;
    logic                 out_valid;
    logic [ID_W-1:0]      out_id;
    logic [2:0]           f_kind, e_kind, c_kind;
    logic [ID_W-1:0]      f_prod, e_prod, c_prod;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    last_arrive_classifier #(.NSRC(NSRC), .TS_W(TS_W), .ID_W(ID_W)) u_last_arrive_classifier (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_id(ret_id),
        .brmisp_prev(brmisp_prev), .rob_full_at_fetch(rob_full_at_fetch),
        .ops_ready_at_fetch(ops_ready_at_fetch), .src_valid(src_valid),
        .src_time(src_time), .src_prod(src_prod), .commit_waited(commit_waited),
        .out_valid(out_valid), .out_id(out_id), .f_kind(f_kind), .f_prod(f_prod),
        .e_kind(e_kind), .e_prod(e_prod), .c_kind(c_kind), .c_prod(c_prod)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected record of the retirement applied on the previous falling edge
    logic            pend = 1'b0;
    logic            x_valid;
    logic [ID_W-1:0] x_id, x_fp, x_ep, x_cp;
    logic [2:0]      x_fk, x_ek, x_ck;
    string           t_f, t_e, t_c;

    // Bench-side predecessor tracking
    logic            b_have = 1'b0;
    logic [ID_W-1:0] b_prev = '0;
    logic            b_gap = 1'b0;

    task automatic compare_pending();
        if (pend) begin
            chk("R2", "out_valid", 32'(out_valid), 32'(x_valid));
            if (x_valid) begin
                chk("R2", "out_id", 32'(out_id), 32'(x_id));
                chk(t_f, "f_kind", 32'(f_kind), 32'(x_fk));
                chk(t_f, "f_prod", 32'(f_prod), 32'(x_fp));
                chk(t_e, "e_kind", 32'(e_kind), 32'(x_ek));
                chk(t_e, "e_prod", 32'(e_prod), 32'(x_ep));
                chk(t_c, "c_kind", 32'(c_kind), 32'(x_ck));
                chk(t_c, "c_prod", 32'(c_prod), 32'(x_cp));
            end
        end
    endtask

    task automatic apply_idle();
        @(negedge clk);
        compare_pending();
        ret_valid = 1'b0;
        x_valid = 1'b0;
        pend = 1'b1;
        b_gap = 1'b1;
    endtask

    task automatic apply_ret(input int v);
        int maxt;
        int nmax;
        int win;
        logic anyv;
        @(negedge clk);
        compare_pending();
        ret_valid          = 1'b1;
        ret_id             = ID_W'(v * 7 + 3);
        src_time           = (NSRC*TS_W)'(v);
        src_valid          = NSRC'(v >> (NSRC*TS_W));
        ops_ready_at_fetch = v[NSRC*TS_W + NSRC];
        brmisp_prev        = v[NSRC*TS_W + NSRC + 1];
        rob_full_at_fetch  = v[NSRC*TS_W + NSRC + 2];
        commit_waited      = v[NSRC*TS_W + NSRC + 3];
        for (int g = 0; g < NSRC; g++)
            src_prod[g*ID_W +: ID_W] = ID_W'(8'h40 + 16*g + (v % 13));

        x_valid = 1'b1;
        x_id    = ret_id;

        // Fetch node
        if (!b_have) begin
            x_fk = 3'd7; x_fp = '0; t_f = "R9";
        end else begin
            x_fp = b_prev;
            if (brmisp_prev)            begin x_fk = 3'd2; t_f = "R3"; end
            else if (rob_full_at_fetch) begin x_fk = 3'd1; t_f = "R4"; end
            else                        begin x_fk = 3'd0; t_f = "R4"; end
            if (b_gap) t_f = "R10";
        end

        // Execute node: find the largest stamp, then the first source holding it
        anyv = 1'b0; maxt = -1; nmax = 0; win = 0;
        for (int g = 0; g < NSRC; g++)
            if (src_valid[g] && int'(src_time[g*TS_W +: TS_W]) > maxt)
                maxt = int'(src_time[g*TS_W +: TS_W]);
        for (int g = NSRC - 1; g >= 0; g--)
            if (src_valid[g] && int'(src_time[g*TS_W +: TS_W]) == maxt) begin
                anyv = 1'b1; nmax++; win = g;
            end
        if (ops_ready_at_fetch || !anyv) begin
            x_ek = 3'd3; x_ep = ret_id; t_e = "R5";
        end else begin
            x_ek = 3'd4; x_ep = src_prod[win*ID_W +: ID_W];
            t_e = (nmax > 1) ? "R7" : "R6";
        end

        // Commit node
        if (commit_waited) begin
            x_ck = 3'd5; x_cp = ret_id; t_c = "R8";
        end else if (!b_have) begin
            x_ck = 3'd7; x_cp = '0; t_c = "R9";
        end else begin
            x_ck = 3'd6; x_cp = b_prev; t_c = b_gap ? "R10" : "R8";
        end

        pend   = 1'b1;
        b_have = 1'b1;
        b_prev = ret_id;
        b_gap  = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        for (int v = 0; v < SWEEP; v++) begin
            apply_ret(v);
            if (v % 97 == 5) begin
                apply_idle();
                apply_idle();
            end
        end
        apply_idle();
        // Reset again mid-stream: predecessor must be forgotten (R1, R9)
        @(negedge clk);
        compare_pending();
        pend = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid during second reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        b_have = 1'b0;
        b_gap = 1'b0;
        apply_ret(0);
        apply_ret(SWEEP - 1);
        apply_idle();
        @(negedge clk);
        compare_pending();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule